// File: doc/BRIEF.md
# Peripheral Slot Sense/Control Scanner

This block sits between a host controller and a row of plug-in peripheral cards. All cards share one 8-bit sense bus (card to block), one 8-bit control bus (block to card), a 2-bit circuit address, a read strobe and a write strobe. Each card also has its own select line. The block walks through the slots on its own. It reads each card circuit's sense word and remembers what it has seen. It reports a new word to the host only after the same new word has been read twice in a row from that circuit. A single odd read is treated as noise and is never reported.

A static per-slot input tells the scanner what kind of card is fitted. A line-style card is read once per pass with circuit address 0, and its eight bits are the hook states of eight lines. An addressed card is read four times per pass, once for each circuit address 0 to 3. Confirmed changes leave the block on a valid/ready event stream. The stream holds slot, circuit, new word and changed-bit mask. A head item stays unchanged while `evt_valid` is high and `evt_ready` is low. When eight events are waiting, the scanner starts no new read until the host takes one, so no event is ever dropped. The host issues control writes on a second valid/ready stream. A command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the bus is idle between accesses.

Top module: `slot_scan_top`

## Requirements
- R1: While reset is held and just after it is released, every select line, `rd_stb`, `wr_stb` and `evt_valid` is low, `cir_addr` and `ctl_bus` are zero, and `cmd_ready` is high.
- R2: Each bus access spans four cycles. There is an idle cycle with nothing driven, then one setup cycle with the select and address driven and no strobe, then two cycles with the strobe high. A read samples `sense_bus` at the clock edge that ends the second strobe cycle. At most one select line is high at any time, and select and address stay stable while a strobe is high.
- R3: Scan reads visit slots 0 up to NUM_SLOTS-1 in ascending order and then wrap to 0. An addressed slot is read at circuit addresses 0, 1, 2, 3 in that order before the scan moves on.
- R4: A slot whose `cfg_line` bit is 1 is read once per pass with `cir_addr` = 0, and all eight sense bits form one word.
- R5: A read equal to the stored confirmed word of that slot/circuit raises no event and discards any pending candidate. Confirmed words are zero after reset.
- R6: The first read that differs from the confirmed word raises no event and becomes the candidate. The next read of the same slot/circuit that returns the same candidate raises an event and makes that word the confirmed word.
- R7: A differing read that also differs from the current candidate replaces the candidate and raises no event.
- R8: An event carries `evt_slot`, `evt_cir` (0 for line cards), `evt_word` = the new confirmed word and `evt_mask` = new word XOR the previous confirmed word. For example, a trunk circuit going from 0x00 to 0x40 reports mask 0x40 (bit 6).
- R9: Events leave in the order they were confirmed, up to 8 are held, and the head fields are stable while `evt_valid` is high and `evt_ready` is low.
- R10: While 8 events are held, no new scan read is started. Scanning resumes once the host takes an event, and no event is lost.
- R11: A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high, and it is served before the next scan read. It drives the select of `cmd_slot`, `cir_addr` = `cmd_cir` and `ctl_bus` = `cmd_data` for the setup cycle and then for two cycles with `wr_stb` high.
- R12: A command whose `cmd_slot` is NUM_SLOTS or above drives no select line but still runs the full write strobe sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_line | input | NUM_SLOTS | Per slot: 1 = line card, 0 = addressed card |
| sense_bus | input | 8 | Shared sense word from the selected card |
| slot_sel | output | NUM_SLOTS | One select line per slot |
| cir_addr | output | 2 | Circuit address on the card |
| ctl_bus | output | 8 | Shared control word to the selected card |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| cmd_valid | input | 1 | Host write command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_slot | input | 6 | Command target slot |
| cmd_cir | input | 2 | Command circuit address |
| cmd_data | input | 8 | Command control word |
| evt_valid | output | 1 | Event present at the head |
| evt_ready | input | 1 | Host takes the head event |
| evt_slot | output | 6 | Event slot |
| evt_cir | output | 2 | Event circuit address |
| evt_word | output | 8 | New confirmed word |
| evt_mask | output | 8 | Bits that changed |

## Verification
A corrupted confirmed or candidate entry shows up as a wrong event. It may be an event that comes one read too early or too late, or one with a wrong mask. It appears at the event port one cycle after the second strobe cycle of the affected read. That read happens at most one scan pass later. A broken sequencer or scan pointer shows up on the select, address or strobe pins in the very cycle it goes wrong. So the bench compares these pins against its own model on every clock. The same per-cycle compare covers the event head, so a lost, reordered or changing queued event is seen in the cycle it happens.

// File: rtl/slot_scan_pkg.sv
package slot_scan_pkg;
  // Bus access phases; a read samples the sense bus on the edge leaving PH_STB2
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_STB1  = 2'd2,
    PH_STB2  = 2'd3
  } phase_e;
endpackage

// File: rtl/slot_scan_seq.sv
module slot_scan_seq
  import slot_scan_pkg::*;
#(
  parameter int NUM_SLOTS = 41,
  parameter int DATA_W    = 8,
  parameter int CIR_W     = 2,
  parameter int SLOT_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] cfg_line,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [SLOT_W-1:0]    cmd_slot,
  input  logic [CIR_W-1:0]     cmd_cir,
  input  logic [DATA_W-1:0]    cmd_data,
  input  logic                 fifo_full,
  output logic [NUM_SLOTS-1:0] slot_sel,
  output logic [CIR_W-1:0]     cir_addr,
  output logic [DATA_W-1:0]    ctl_bus,
  output logic                 rd_stb,
  output logic                 wr_stb,
  output logic                 smp_en,
  output logic [SLOT_W-1:0]    smp_slot,
  output logic [CIR_W-1:0]     smp_cir
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [CIR_W-1:0]  LAST_CIR  = '1;

  phase_e              phase;
  logic                op_wr;
  logic                op_line;
  logic [SLOT_W-1:0]   op_slot;
  logic [CIR_W-1:0]    op_cir;
  logic [DATA_W-1:0]   op_data;
  logic [SLOT_W-1:0]   scan_slot;
  logic [CIR_W-1:0]    scan_cir;
  logic                scan_line;
  logic                active;
  logic                strobing;

  assign scan_line = cfg_line[scan_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      op_wr     <= 1'b0;
      op_line   <= 1'b0;
      op_slot   <= '0;
      op_cir    <= '0;
      op_data   <= '0;
      scan_slot <= '0;
      scan_cir  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (cmd_valid) begin
            // host write wins the gap between scan reads
            op_wr   <= 1'b1;
            op_line <= 1'b0;
            op_slot <= cmd_slot;
            op_cir  <= cmd_cir;
            op_data <= cmd_data;
            phase   <= PH_SETUP;
          end else if (!fifo_full) begin
            op_wr   <= 1'b0;
            op_line <= scan_line;
            op_slot <= scan_slot;
            op_cir  <= scan_line ? '0 : scan_cir;
            op_data <= '0;
            phase   <= PH_SETUP;
          end
        end
        PH_SETUP: phase <= PH_STB1;
        PH_STB1:  phase <= PH_STB2;
        PH_STB2: begin
          phase <= PH_IDLE;
          if (!op_wr) begin
            if (op_line || (scan_cir == LAST_CIR)) begin
              scan_cir  <= '0;
              scan_slot <= (scan_slot == LAST_SLOT) ? '0 : scan_slot + 1'b1;
            end else begin
              scan_cir <= scan_cir + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign active   = (phase != PH_IDLE);
  assign strobing = (phase == PH_STB1) || (phase == PH_STB2);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
    assign slot_sel[g] = active && (op_slot == SLOT_W'(g));
  end

  assign cir_addr  = active ? op_cir : '0;
  assign ctl_bus   = (active && op_wr) ? op_data : '0;
  assign rd_stb    = strobing && !op_wr;
  assign wr_stb    = strobing && op_wr;
  assign cmd_ready = (phase == PH_IDLE);
  assign smp_en    = (phase == PH_STB2) && !op_wr;
  assign smp_slot  = op_slot;
  assign smp_cir   = op_cir;
endmodule

// File: rtl/slot_scan_track.sv
module slot_scan_track #(
  parameter int NUM_SLOTS = 41,
  parameter int DATA_W    = 8,
  parameter int CIR_W     = 2,
  parameter int SLOT_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic [SLOT_W-1:0] smp_slot,
  input  logic [CIR_W-1:0]  smp_cir,
  input  logic [DATA_W-1:0] smp_word,
  output logic              push,
  output logic [SLOT_W-1:0] push_slot,
  output logic [CIR_W-1:0]  push_cir,
  output logic [DATA_W-1:0] push_word,
  output logic [DATA_W-1:0] push_mask
);
  localparam int ENTRIES = NUM_SLOTS << CIR_W;
  localparam int IDX_W   = SLOT_W + CIR_W;

  logic [DATA_W-1:0] conf  [ENTRIES];
  logic [DATA_W-1:0] cand  [ENTRIES];
  logic              cand_v[ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] cur_conf;
  logic              same;
  logic              hit;

  assign idx      = {smp_slot, smp_cir};
  assign cur_conf = conf[idx];
  assign same     = (smp_word == cur_conf);
  assign hit      = cand_v[idx] && (smp_word == cand[idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        conf[i]   <= '0;
        cand[i]   <= '0;
        cand_v[i] <= 1'b0;
      end
    end else if (smp_en) begin
      if (same) begin
        cand_v[idx] <= 1'b0;
      end else if (hit) begin
        conf[idx]   <= smp_word;
        cand_v[idx] <= 1'b0;
      end else begin
        cand[idx]   <= smp_word;
        cand_v[idx] <= 1'b1;
      end
    end
  end

  assign push      = smp_en && !same && hit;
  assign push_slot = smp_slot;
  assign push_cir  = smp_cir;
  assign push_word = smp_word;
  assign push_mask = smp_word ^ cur_conf;
endmodule

// File: rtl/slot_scan_fifo.sv
module slot_scan_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             full,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push;
  logic             do_pop;

  assign full      = (count == CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = in_valid && !full;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/slot_scan_top.sv
module slot_scan_top #(
  parameter int NUM_SLOTS = 41,
  parameter int DATA_W    = 8,
  parameter int CIR_W     = 2,
  parameter int SLOT_W    = 6,
  parameter int EVT_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] cfg_line,
  input  logic [DATA_W-1:0]    sense_bus,
  output logic [NUM_SLOTS-1:0] slot_sel,
  output logic [CIR_W-1:0]     cir_addr,
  output logic [DATA_W-1:0]    ctl_bus,
  output logic                 rd_stb,
  output logic                 wr_stb,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [SLOT_W-1:0]    cmd_slot,
  input  logic [CIR_W-1:0]     cmd_cir,
  input  logic [DATA_W-1:0]    cmd_data,
  output logic                 evt_valid,
  input  logic                 evt_ready,
  output logic [SLOT_W-1:0]    evt_slot,
  output logic [CIR_W-1:0]     evt_cir,
  output logic [DATA_W-1:0]    evt_word,
  output logic [DATA_W-1:0]    evt_mask
);
  localparam int EVT_W = SLOT_W + CIR_W + 2 * DATA_W;

  logic              fifo_full;
  logic              smp_en;
  logic [SLOT_W-1:0] smp_slot;
  logic [CIR_W-1:0]  smp_cir;
  logic              push;
  logic [SLOT_W-1:0] push_slot;
  logic [CIR_W-1:0]  push_cir;
  logic [DATA_W-1:0] push_word;
  logic [DATA_W-1:0] push_mask;
  logic [EVT_W-1:0]  head;

  slot_scan_seq #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .CIR_W(CIR_W), .SLOT_W(SLOT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_line(cfg_line),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_slot(cmd_slot), .cmd_cir(cmd_cir), .cmd_data(cmd_data),
    .fifo_full(fifo_full),
    .slot_sel(slot_sel), .cir_addr(cir_addr), .ctl_bus(ctl_bus),
    .rd_stb(rd_stb), .wr_stb(wr_stb),
    .smp_en(smp_en), .smp_slot(smp_slot), .smp_cir(smp_cir)
  );

  slot_scan_track #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .CIR_W(CIR_W), .SLOT_W(SLOT_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n),
    .smp_en(smp_en), .smp_slot(smp_slot), .smp_cir(smp_cir), .smp_word(sense_bus),
    .push(push), .push_slot(push_slot), .push_cir(push_cir),
    .push_word(push_word), .push_mask(push_mask)
  );

  slot_scan_fifo #(
    .WIDTH(EVT_W), .DEPTH(EVT_DEPTH)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(push), .in_data({push_slot, push_cir, push_word, push_mask}),
    .full(fifo_full),
    .out_valid(evt_valid), .out_ready(evt_ready), .out_data(head)
  );

  assign {evt_slot, evt_cir, evt_word, evt_mask} = head;
endmodule

// File: rtl/slot_scan_chk.sv
module slot_scan_chk #(
  parameter int NUM_SLOTS = 41,
  parameter int DATA_W    = 8,
  parameter int CIR_W     = 2,
  parameter int SLOT_W    = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] cfg_line,
  input logic [NUM_SLOTS-1:0] slot_sel,
  input logic [CIR_W-1:0]     cir_addr,
  input logic                 rd_stb,
  input logic                 wr_stb,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic                 evt_valid,
  input logic                 evt_ready,
  input logic [SLOT_W-1:0]    evt_slot,
  input logic [CIR_W-1:0]     evt_cir,
  input logic [DATA_W-1:0]    evt_word,
  input logic [DATA_W-1:0]    evt_mask,
  input logic                 fifo_full
);
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_sel) <= 1);

  a_r2_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_stb) |-> ($past(slot_sel) == slot_sel) && ($past(cir_addr) == cir_addr));

  a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> $stable(slot_sel) && $stable(cir_addr));

  a_r2_two_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_stb) |=> rd_stb);

  a_r2_not_three: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && $past(rd_stb) |=> !rd_stb);

  a_r4_line_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && ((slot_sel & cfg_line) != '0) |-> cir_addr == '0);

  a_r8_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_mask != '0);

  a_r9_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_slot) && $stable(evt_cir)
                                && $stable(evt_word) && $stable(evt_mask));

  a_r10_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && cmd_ready && !cmd_valid |=> !rd_stb && (slot_sel == '0));

  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (slot_sel == '0) && !rd_stb && !wr_stb);

  a_r11_write_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_stb) |=> wr_stb);
endmodule

bind slot_scan_top slot_scan_chk #(
  .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .CIR_W(CIR_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_line(cfg_line), .slot_sel(slot_sel),
  .cir_addr(cir_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_slot(evt_slot),
  .evt_cir(evt_cir), .evt_word(evt_word), .evt_mask(evt_mask),
  .fifo_full(fifo_full)
);

// File: tb/slot_scan_top_tb_top.sv
module slot_scan_top_tb_top;
  localparam int NS = 41;
  localparam int SW = 6;
  localparam int NE = NS * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] cfg_line;
  logic [7:0]    sense_bus;
  logic [NS-1:0] slot_sel;
  logic [1:0]    cir_addr;
  logic [7:0]    ctl_bus;
  logic          rd_stb, wr_stb;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [SW-1:0] cmd_slot = '0;
  logic [1:0]    cmd_cir = '0;
  logic [7:0]    cmd_data = '0;
  logic          evt_valid;
  logic          evt_ready = 1'b1;
  logic [SW-1:0] evt_slot;
  logic [1:0]    evt_cir;
  logic [7:0]    evt_word, evt_mask;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  slot_scan_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_line(cfg_line), .sense_bus(sense_bus),
    .slot_sel(slot_sel), .cir_addr(cir_addr), .ctl_bus(ctl_bus),
    .rd_stb(rd_stb), .wr_stb(wr_stb),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_slot(cmd_slot),
    .cmd_cir(cmd_cir), .cmd_data(cmd_data),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_slot(evt_slot),
    .evt_cir(evt_cir), .evt_word(evt_word), .evt_mask(evt_mask)
  );

  // card model: each slot/circuit returns its stored word while selected and read
  logic [7:0] card [NE];
  always_comb begin
    sense_bus = 8'h00;
    for (int i = 0; i < NS; i++)
      if (rd_stb && slot_sel[i]) sense_bus = card[i * 4 + int'(cir_addr)];
  end

  task automatic chk(input string tag, input string what, input logic [63:0] a, input logic [63:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, a, e);
    end
  endtask

  // ---------------- reference model, advanced on each rising edge ----------------
  int         m_ph, m_slot, m_cir, sc_s, sc_c, mk;
  bit         m_wr, m_line, m_full;
  logic [7:0] m_data, mw;
  logic [7:0] m_conf [NE];
  logic [7:0] m_cand [NE];
  bit         m_cv   [NE];
  logic [23:0] mq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_wr = 0; m_line = 0; m_slot = 0; m_cir = 0; m_data = 0;
      sc_s = 0; sc_c = 0; mq.delete();
      for (int i = 0; i < NE; i++) begin m_conf[i] = 0; m_cand[i] = 0; m_cv[i] = 0; end
    end else begin
      m_full = (mq.size() >= 8);
      if (mq.size() > 0 && evt_ready) void'(mq.pop_front());
      case (m_ph)
        0: begin
          if (cmd_valid) begin
            m_wr = 1; m_line = 0; m_slot = int'(cmd_slot); m_cir = int'(cmd_cir);
            m_data = cmd_data; m_ph = 1;
          end else if (!m_full) begin
            m_wr = 0; m_line = cfg_line[sc_s]; m_slot = sc_s;
            m_cir = m_line ? 0 : sc_c; m_data = 0; m_ph = 1;
          end
        end
        1: m_ph = 2;
        2: m_ph = 3;
        default: begin
          m_ph = 0;
          if (!m_wr) begin
            mk = m_slot * 4 + m_cir;
            mw = sense_bus;
            if (mw == m_conf[mk]) m_cv[mk] = 0;
            else if (m_cv[mk] && mw == m_cand[mk]) begin
              mq.push_back({SW'(m_slot), 2'(m_cir), mw, mw ^ m_conf[mk]});
              m_conf[mk] = mw; m_cv[mk] = 0;
            end else begin
              m_cand[mk] = mw; m_cv[mk] = 1;
            end
            if (m_line || sc_c == 3) begin
              sc_c = 0; sc_s = (sc_s == NS - 1) ? 0 : sc_s + 1;
            end else sc_c = sc_c + 1;
          end
        end
      endcase
    end
  end

  // ---------------- per-cycle compare and monitors on the falling edge ----------------
  int          rd_done [NE];
  int          prev_k = 0;
  bit          prev_rd = 0;
  int          rd_cycles = 0;
  int          wr_cycles = 0;
  logic [NS-1:0] wr_sel_seen = '0;
  logic [1:0]  wr_cir_seen = '0;
  logic [7:0]  wr_data_seen = '0;
  logic [23:0] obs[$];

  initial for (int i = 0; i < NE; i++) rd_done[i] = 0;

  always @(negedge clk) begin
    logic [NS-1:0] e_sel;
    bit act;
    act   = (m_ph != 0);
    e_sel = (act && m_slot < NS) ? (NS'(1) << m_slot) : '0;
    chk("R3", "slot_sel", 64'(slot_sel), 64'(e_sel));
    chk("R3", "cir_addr", 64'(cir_addr), act ? 64'(m_cir) : 64'd0);
    chk("R2", "rd_stb", 64'(rd_stb), 64'(!m_wr && m_ph >= 2));
    chk("R11", "wr_stb", 64'(wr_stb), 64'(m_wr && m_ph >= 2));
    chk("R11", "ctl_bus", 64'(ctl_bus), (act && m_wr) ? 64'(m_data) : 64'd0);
    chk("R11", "cmd_ready", 64'(cmd_ready), 64'(m_ph == 0));
    chk("R9", "evt_valid", 64'(evt_valid), 64'(mq.size() > 0));
    if (mq.size() > 0)
      chk("R8", "event head", 64'({evt_slot, evt_cir, evt_word, evt_mask}), 64'(mq[0]));
    if (rd_stb) begin
      rd_cycles++;
      for (int i = 0; i < NS; i++) if (slot_sel[i]) prev_k = i * 4 + int'(cir_addr);
    end
    if (prev_rd && !rd_stb) rd_done[prev_k]++;
    prev_rd = rd_stb;
    if (wr_stb) begin
      wr_cycles++;
      wr_sel_seen  = wr_sel_seen | slot_sel;
      wr_cir_seen  = cir_addr;
      wr_data_seen = ctl_bus;
    end
    if (evt_valid && evt_ready) obs.push_back({evt_slot, evt_cir, evt_word, evt_mask});
  end

  // ---------------- helpers ----------------
  task automatic wait_reads(input int s, input int c, input int n);
    int target;
    target = rd_done[s * 4 + c] + n;
    while (rd_done[s * 4 + c] < target) @(negedge clk);
  endtask

  task automatic expect_evt(input string tag, input int s, input int c,
                            input logic [7:0] w, input logic [7:0] m);
    logic [23:0] got;
    total++;
    if (obs.size() == 0) begin
      bad++;
      $display("FAIL %s event actual=none expected=%0h", tag, {SW'(s), 2'(c), w, m});
    end else begin
      got = obs.pop_front();
      if (got !== {SW'(s), 2'(c), w, m}) begin
        bad++;
        $display("FAIL %s event actual=%0h expected=%0h", tag, got, {SW'(s), 2'(c), w, m});
      end
    end
  endtask

  task automatic send_cmd(input int s, input int c, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_slot = SW'(s); cmd_cir = 2'(c); cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int w0;
    cfg_line = '0;
    for (int i = 0; i < 10; i++) cfg_line[i] = 1'b1;
    cfg_line[40] = 1'b1;
    for (int i = 0; i < NE; i++) card[i] = 8'h00;

    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "sel in reset", 64'(slot_sel), 64'd0);
    chk("R1", "strobes in reset", 64'({rd_stb, wr_stb}), 64'd0);
    chk("R1", "evt_valid in reset", 64'(evt_valid), 64'd0);
    chk("R1", "cmd_ready in reset", 64'(cmd_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "bus after reset", 64'({cir_addr, ctl_bus}), 64'd0);

    // R5: all words equal the reset confirmed value, nothing reported
    repeat (1200) @(negedge clk);
    chk("R5", "events with quiet cards", 64'(obs.size()), 64'd0);

    // R6/R8: seizure on a trunk circuit, bit 6
    card[12 * 4 + 2] = 8'h40;
    wait_reads(12, 2, 1);
    repeat (3) @(negedge clk);
    chk("R6", "no event after first differing read", 64'(obs.size()), 64'd0);
    wait_reads(12, 2, 1);
    repeat (3) @(negedge clk);
    expect_evt("R6", 12, 2, 8'h40, 8'h40);

    // R4: line card, eight hook bits in one word
    card[3 * 4] = 8'h81;
    wait_reads(3, 0, 2);
    repeat (3) @(negedge clk);
    expect_evt("R4", 3, 0, 8'h81, 8'h81);
    card[3 * 4] = 8'h80;
    wait_reads(3, 0, 2);
    repeat (3) @(negedge clk);
    expect_evt("R8", 3, 0, 8'h80, 8'h01);

    // R7: candidate replaced by a different word
    card[20 * 4 + 1] = 8'h11;
    wait_reads(20, 1, 1);
    card[20 * 4 + 1] = 8'h22;
    wait_reads(20, 1, 1);
    repeat (3) @(negedge clk);
    chk("R7", "no event on replaced candidate", 64'(obs.size()), 64'd0);
    wait_reads(20, 1, 1);
    repeat (3) @(negedge clk);
    expect_evt("R7", 20, 1, 8'h22, 8'h22);

    // R5: a glitch that returns to the confirmed word drops the candidate
    card[20 * 4 + 1] = 8'h23;
    wait_reads(20, 1, 1);
    card[20 * 4 + 1] = 8'h22;
    wait_reads(20, 1, 1);
    card[20 * 4 + 1] = 8'h23;
    wait_reads(20, 1, 1);
    repeat (3) @(negedge clk);
    chk("R5", "no event after glitch", 64'(obs.size()), 64'd0);
    wait_reads(20, 1, 1);
    repeat (3) @(negedge clk);
    expect_evt("R5", 20, 1, 8'h23, 8'h01);

    // R11: host control write
    w0 = wr_cycles; wr_sel_seen = '0;
    send_cmd(7, 3, 8'hA5);
    chk("R11", "write strobe cycles", 64'(wr_cycles - w0), 64'd2);
    chk("R11", "write select", 64'(wr_sel_seen), 64'(NS'(1) << 7));
    chk("R11", "write addr/data", 64'({wr_cir_seen, wr_data_seen}), 64'({2'd3, 8'hA5}));

    // R12: slot beyond the last one selects nothing
    w0 = wr_cycles; wr_sel_seen = '0;
    send_cmd(50, 1, 8'h3C);
    chk("R12", "write strobe cycles", 64'(wr_cycles - w0), 64'd2);
    chk("R12", "no select", 64'(wr_sel_seen), 64'd0);

    // R10: ten events against an 8-deep queue with the host not taking
    @(negedge clk);
    evt_ready = 1'b0;
    for (int s = 30; s < 35; s++) begin
      card[s * 4]     = 8'h5A;
      card[s * 4 + 1] = 8'hC3;
    end
    wait_reads(33, 1, 2);
    repeat (20) @(negedge clk);
    w0 = rd_cycles;
    repeat (200) @(negedge clk);
    chk("R10", "reads while queue full", 64'(rd_cycles - w0), 64'd0);
    chk("R10", "events held", 64'(evt_valid), 64'd1);
    evt_ready = 1'b1;
    wait_reads(34, 1, 2);
    repeat (20) @(negedge clk);
    chk("R9", "events delivered", 64'(obs.size()), 64'd10);
    for (int s = 30; s < 35; s++) begin
      expect_evt("R9", s, 0, 8'h5A, 8'h5A);
      expect_evt("R9", s, 1, 8'hC3, 8'hC3);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule